// File: doc/BRIEF.md
# Receive Destination Filter and Descriptor Status Builder

This block sits at the end of an Ethernet receive path. When the receive MAC reports that a frame has finished, the block looks at the frame's destination address. It sorts the address into one of three classes: broadcast, multicast or unicast. It then applies the filter policy that is currently programmed and decides whether the frame is kept.

For a kept frame the block assembles the 32-bit word that the descriptor engine writes back to the host. That word carries:

- the ownership tag,
- a good-frame flag,
- the destination class,
- the individual error indications,
- the byte count.

A rejected frame produces no write.

The station address is loaded as three 16-bit halves through a small write port. The filter policy is a set of independent accept bits under a master enable. Every result appears exactly one clock after the frame-done strobe.

Top module: `rxfilt_top`

## Requirements
- R1: After reset, resultValid, accept, destClass, stsWrite and stsWord are all 0, and the station address is all zeros.
- R2: A write with staWe high and staSel k (0, 1 or 2) stores staData into station word k. Address byte 2k goes in the low half (staData[7:0]) and byte 2k+1 in the high half. Byte 0 is dstAddr[7:0]. A write with staSel 3 changes nothing.
- R3: When filtCtl[4] (filter enable) is 0, every frame is rejected: accept 0, destClass 0, no status write.
- R4: An all-ones destination is broadcast (class 3). It is accepted only when filtCtl[3] is set.
- R5: A destination that is not all ones and has dstAddr[0] set is multicast (class 2). It is accepted only when filtCtl[2] is set.
- R6: Any other destination is unicast (class 1). It is accepted when filtCtl[1] is set, or when filtCtl[0] is set and the destination equals the station address.
- R7: resultValid pulses for one cycle, one clock after each frameDone cycle. stsWrite is high only in that cycle and only for an accepted frame. Otherwise stsWord is 0.
- R8: A written status word has bit 31 (ownership) set and bits 24:23 equal to the destination class. Bits 11:0 hold frameLen unchanged, so the count includes the CRC. Bits 30:28 and 15:12 are 0.
- R9: errIn bits are copied into the status word as follows:
  - [6] receive abort → bit 26
  - [5] overrun → bit 25
  - [4] invalid symbol → bit 20
  - [3] CRC error → bit 19
  - [2] alignment error → bit 18
  - [1] loopback → bit 17
  - [0] collision → bit 16
- R10: Bit 22 is set when frameLen exceeds MAX_LEN. Bit 21 is set when frameLen is below MIN_LEN.
- R11: Bit 27 (good frame) is set exactly when the frame is accepted and none of bits 26, 25 or 22:16 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| staWe | input | 1 | Station address word write strobe |
| staSel | input | 2 | Station word index (0..2) |
| staData | input | 16 | Station word value |
| filtCtl | input | 5 | [4] enable, [3] all broadcast, [2] all multicast, [1] all unicast, [0] exact station match |
| frameDone | input | 1 | Frame end strobe; qualifies dstAddr, frameLen, errIn |
| dstAddr | input | 48 | Destination address, first byte in bits 7:0 |
| frameLen | input | LEN_W | Received byte count including CRC |
| errIn | input | 7 | Receive error flags from the MAC |
| resultValid | output | 1 | One-cycle result strobe |
| accept | output | 1 | Frame kept |
| destClass | output | 2 | 0 rejected, 1 unicast, 2 multicast, 3 broadcast |
| stsWrite | output | 1 | Status word write request |
| stsWord | output | 32 | Descriptor status word |

## Verification
The bench builds the block with the default parameters: LEN_W of 12, MAX_LEN of 1518 and MIN_LEN of 64. With these values the bench can drive lengths 63, 64, 1518 and 1519 directly, as well as values near the top of the 12-bit count. Random frames mix all three address classes, station hits and near-misses, every combination of filter bits, and sparse error flags. Directed cases cover the disabled filter, the ignored station index, and each single error flag.

// File: rtl/rxfilt_pkg.sv
package rxfilt_pkg;
  localparam int ADDR_W = 48;
  localparam int HALF_W = 16;
  localparam int NWORDS = ADDR_W / HALF_W;
  localparam int ERR_W = 7;
  localparam int CTL_W = 5;

  typedef enum logic [1:0] {
    CLS_REJ   = 2'd0,
    CLS_UNI   = 2'd1,
    CLS_MULTI = 2'd2,
    CLS_BCAST = 2'd3
  } dest_cls_e;

  typedef struct packed {
    logic       capture;
    logic       staLoad;
    logic [1:0] staSel;
  } rxf_strobe_t;
endpackage

// File: rtl/rxfilt_ctrl.sv
module rxfilt_ctrl
  import rxfilt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameDone,
  input  logic        staWe,
  input  logic [1:0]  staSel,
  output rxf_strobe_t stb,
  output logic        resultValid
);
  always_comb begin
    stb.capture = frameDone;
    stb.staLoad = staWe;
    stb.staSel  = staSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) resultValid <= 1'b0;
    else       resultValid <= frameDone;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> resultValid); // R7
  AST_VALID_SOURCED: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(frameDone)); // R7
endmodule

// File: rtl/rxfilt_dp.sv
module rxfilt_dp
  import rxfilt_pkg::*;
#(
  parameter int LEN_W   = 12,
  parameter int MAX_LEN = 1518,
  parameter int MIN_LEN = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rxf_strobe_t          stb,
  input  logic [HALF_W-1:0]    staData,
  input  logic [CTL_W-1:0]     filtCtl,
  input  logic [ADDR_W-1:0]    dstAddr,
  input  logic [LEN_W-1:0]     frameLen,
  input  logic [ERR_W-1:0]     errIn,
  output logic                 accept,
  output logic [1:0]           destClass,
  output logic                 stsWrite,
  output logic [31:0]          stsWord
);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);

  logic [HALF_W-1:0] staWord [NWORDS];
  logic [ADDR_W-1:0] staVec;

  for (genvar k = 0; k < NWORDS; k++) begin : g_sta
    always_ff @(posedge clk) begin
      if (!rstN) staWord[k] <= '0;
      else if (stb.staLoad && stb.staSel == 2'(k)) staWord[k] <= staData;
    end
    assign staVec[k*HALF_W +: HALF_W] = staWord[k];
  end

  logic isBcast, isMcast, staHit, keep, isLong, isRunt, anyErr;
  dest_cls_e cls;
  logic [31:0] wordNext;

  always_comb begin
    isBcast = &dstAddr;
    isMcast = !isBcast && dstAddr[0];
    staHit  = (dstAddr == staVec);
    if (isBcast)      cls = CLS_BCAST;
    else if (isMcast) cls = CLS_MULTI;
    else              cls = CLS_UNI;
    unique case (cls)
      CLS_BCAST: keep = filtCtl[3];
      CLS_MULTI: keep = filtCtl[2];
      default:   keep = filtCtl[1] || (filtCtl[0] && staHit);
    endcase
    keep   = keep && filtCtl[4];
    isLong = frameLen > MAX_L;
    isRunt = frameLen < MIN_L;
    anyErr = (|errIn) || isLong || isRunt;

    wordNext          = '0;
    wordNext[31]      = 1'b1;
    wordNext[27]      = !anyErr;
    wordNext[26]      = errIn[6];
    wordNext[25]      = errIn[5];
    wordNext[24:23]   = cls;
    wordNext[22]      = isLong;
    wordNext[21]      = isRunt;
    wordNext[20:16]   = errIn[4:0];
    wordNext[LEN_W-1:0] = frameLen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accept    <= 1'b0;
      destClass <= CLS_REJ;
      stsWrite  <= 1'b0;
      stsWord   <= '0;
    end else if (stb.capture) begin
      accept    <= keep;
      destClass <= keep ? cls : CLS_REJ;
      stsWrite  <= keep;
      stsWord   <= keep ? wordNext : '0;
    end else begin
      stsWrite  <= 1'b0;
      stsWord   <= '0;
    end
  end

  AST_DISABLED_REJECTS: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture && !filtCtl[4] |=> !accept && destClass == CLS_REJ && !stsWrite); // R3
  AST_OWNED_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    stsWrite |-> stsWord[31] && stsWord[24:23] != 2'd0); // R8
  AST_GOOD_IMPLIES_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    stsWord[27] |-> stsWord[26:25] == 2'd0 && stsWord[22:16] == 7'd0); // R11
  AST_COUNT_COPIED: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> (stsWrite ? stsWord[LEN_W-1:0] == $past(frameLen) : stsWord == 32'd0)); // R8
  AST_LONG_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture && frameLen > MAX_L |=> !stsWrite || stsWord[22]); // R10
  AST_BCAST_CLASS: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture && (&dstAddr) && filtCtl[4] && filtCtl[3] |=> destClass == CLS_BCAST); // R4
endmodule

// File: rtl/rxfilt_top.sv
module rxfilt_top
  import rxfilt_pkg::*;
#(
  parameter int LEN_W   = 12,
  parameter int MAX_LEN = 1518,
  parameter int MIN_LEN = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              staWe,
  input  logic [1:0]        staSel,
  input  logic [15:0]       staData,
  input  logic [4:0]        filtCtl,
  input  logic              frameDone,
  input  logic [47:0]       dstAddr,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic [6:0]        errIn,
  output logic              resultValid,
  output logic              accept,
  output logic [1:0]        destClass,
  output logic              stsWrite,
  output logic [31:0]       stsWord
);
  rxf_strobe_t stb;

  rxfilt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameDone(frameDone),
    .staWe(staWe), .staSel(staSel), .stb(stb), .resultValid(resultValid)
  );

  rxfilt_dp #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN), .MIN_LEN(MIN_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .staData(staData), .filtCtl(filtCtl),
    .dstAddr(dstAddr), .frameLen(frameLen), .errIn(errIn),
    .accept(accept), .destClass(destClass), .stsWrite(stsWrite), .stsWord(stsWord)
  );

  AST_WRITE_IN_VALID: assert property (@(posedge clk) disable iff (!rstN)
    stsWrite |-> resultValid && accept); // R7
endmodule

// File: tb/rxfilt_top_bench.sv
module rxfilt_top_bench;
  logic clk = 1'b0;
  logic rstN, staWe, frameDone;
  logic [1:0] staSel;
  logic [15:0] staData;
  logic [4:0] filtCtl;
  logic [47:0] dstAddr;
  logic [11:0] frameLen;
  logic [6:0] errIn;
  logic resultValid, accept, stsWrite;
  logic [1:0] destClass;
  logic [31:0] stsWord;

  int checks = 0;
  int errors = 0;
  logic [47:0] staModel = '0;
  bit done = 0;

  always #5 clk = ~clk;

  rxfilt_top u_rxfilt_top (
    .clk(clk), .rstN(rstN), .staWe(staWe), .staSel(staSel), .staData(staData),
    .filtCtl(filtCtl), .frameDone(frameDone), .dstAddr(dstAddr),
    .frameLen(frameLen), .errIn(errIn), .resultValid(resultValid),
    .accept(accept), .destClass(destClass), .stsWrite(stsWrite), .stsWord(stsWord)
  );

  function automatic logic [1:0] expCls(logic [47:0] d, logic [4:0] c, logic [47:0] s);
    if (!c[4]) return 2'd0;
    if (&d) return c[3] ? 2'd3 : 2'd0;
    if (d[0]) return c[2] ? 2'd2 : 2'd0;
    return (c[1] || (c[0] && d == s)) ? 2'd1 : 2'd0;
  endfunction

  function automatic logic [31:0] expWord(logic [1:0] cl, logic [11:0] len, logic [6:0] e);
    logic [31:0] w;
    w = '0;
    if (cl == 2'd0) return w;
    w[31] = 1'b1;
    w[26] = e[6];
    w[25] = e[5];
    w[24:23] = cl;
    w[22] = len > 12'd1518;
    w[21] = len < 12'd64;
    w[20:16] = e[4:0];
    w[27] = !(w[26] | w[25] | (|w[22:16]));
    w[11:0] = len;
    return w;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic staWrite(logic [1:0] sel, logic [15:0] val);
    @(negedge clk);
    staWe = 1'b1; staSel = sel; staData = val;
    @(negedge clk);
    staWe = 1'b0;
    if (sel != 2'd3) staModel[sel*16 +: 16] = val;
  endtask

  task automatic frame(string tag, logic [47:0] d, logic [11:0] len, logic [6:0] e, logic [4:0] c);
    logic [1:0] cl;
    logic [31:0] w;
    @(negedge clk);
    frameDone = 1'b1; dstAddr = d; frameLen = len; errIn = e; filtCtl = c;
    @(negedge clk);
    frameDone = 1'b0;
    cl = expCls(d, c, staModel);
    w = expWord(cl, len, e);
    check(tag, {28'd0, resultValid, accept, destClass, stsWrite, stsWord},
          {28'd0, 1'b1, cl != 2'd0, cl, cl != 2'd0, w});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'h5eed);
    rstN = 1'b0; staWe = 0; staSel = 0; staData = 0; frameDone = 0;
    filtCtl = 0; dstAddr = 0; frameLen = 0; errIn = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset outputs", {resultValid, accept, destClass, stsWrite, stsWord}, '0);
    // R1: station zero -> a zero unicast hits under exact match only
    frame("R1 station zero", 48'd0, 12'd100, 7'd0, 5'b10001);

    // R2: load station, check byte order via exact match
    staWrite(2'd0, 16'h2200);
    staWrite(2'd1, 16'h4433);
    staWrite(2'd2, 16'h6655);
    frame("R2 station hit", 48'h665544332200, 12'd200, 7'd0, 5'b10001);
    frame("R2 station miss", 48'h665544332202, 12'd200, 7'd0, 5'b10001);
    staWrite(2'd3, 16'hFFFF);  // R2: ignored index
    frame("R2 sel3 ignored", 48'h665544332200, 12'd200, 7'd0, 5'b10001);
    check("R2 sel3 model", {16'd0, staModel}, {16'd0, 48'h665544332200});

    // R3: filter disabled
    frame("R3 disabled bcast", '1, 12'd100, 7'd0, 5'b01111);
    frame("R3 disabled station", 48'h665544332200, 12'd100, 7'd0, 5'b01111);
    // R4 broadcast
    frame("R4 bcast on", '1, 12'd100, 7'd0, 5'b11000);
    frame("R4 bcast off", '1, 12'd100, 7'd0, 5'b10111);
    // R5 multicast
    frame("R5 mcast on", 48'h123456789A01, 12'd100, 7'd0, 5'b10100);
    frame("R5 mcast off", 48'h123456789A01, 12'd100, 7'd0, 5'b11011);
    // R6 unicast
    frame("R6 all uni", 48'h123456789A02, 12'd100, 7'd0, 5'b10010);
    frame("R6 uni off", 48'h123456789A02, 12'd100, 7'd0, 5'b11101);
    // R7: idle cycle after a result
    @(negedge clk);
    check("R7 pulse ends", {resultValid, stsWrite, stsWord}, '0);
    // R10 lengths
    frame("R10 len 63", '1, 12'd63, 7'd0, 5'b11000);
    frame("R10 len 64", '1, 12'd64, 7'd0, 5'b11000);
    frame("R10 len 1518", '1, 12'd1518, 7'd0, 5'b11000);
    frame("R10 len 1519", '1, 12'd1519, 7'd0, 5'b11000);
    frame("R8 len max", '1, 12'hFFF, 7'd0, 5'b11000);
    // R9/R11 single errors
    for (int i = 0; i < 7; i++)
      frame("R9 R11 single error", '1, 12'd300, 7'(1 << i), 5'b11000);

    // random mix (R4 R5 R6 R8 R9 R11)
    for (int n = 0; n < 400; n++) begin
      logic [47:0] d;
      logic [11:0] len;
      logic [6:0] e;
      int pick;
      pick = $urandom_range(0, 4);
      d = {$urandom, $urandom};
      case (pick)
        0: d = '1;
        1: d[0] = 1'b1;
        2: d = staModel;
        3: d = staModel ^ (48'd1 << $urandom_range(1, 47));
        default: d[0] = 1'b0;
      endcase
      case ($urandom_range(0, 5))
        0: len = 12'd63;
        1: len = 12'd1519;
        2: len = 12'($urandom_range(0, 4095));
        default: len = 12'($urandom_range(64, 1518));
      endcase
      e = ($urandom_range(0, 3) == 0) ? 7'($urandom) : 7'd0;
      frame("R7 random frame", d, len, e, 5'($urandom));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule